// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the address and count engine for one legacy-style DMA channel. The processor programs a page register, a 16-bit address register, a 16-bit count register and a mode/mask register through a simple write port. Each write to page, address or count loads a base copy and a working copy together. Each accepted transfer strobe moves the working address one step up or down and lowers the working count by one. The output address is built from the page and working address. In byte mode the mapping is direct. In word mode the address is shifted left by one, A0 is held low and the lowest page bit is dropped.

A transfer taken while the working count is zero is the terminal transfer. The count wraps to all ones, so a programmed value of N-1 gives N transfers. Without autoinitialize, the terminal transfer masks the channel. With autoinitialize, the working page, address and count are restored from their base copies and the channel stays unmasked.

A small state machine tracks the channel. Its states are MASKED, IDLE (unmasked, no request) and REQUEST (unmasked, request seen). Its transitions are as follows. MASKED goes to IDLE or REQUEST when a mode write clears the mask bit. IDLE and REQUEST move between each other following the request input. Either of them goes to MASKED on a mode write that sets the mask bit, or on a terminal transfer without autoinitialize. A mode write takes priority over the terminal transfer.

Top module: `dmach_addr_gen`

## Requirements
- R1: After reset the channel is masked, every base and working register and every mode bit is zero, and svc_req_o and tc_o are low, so addr_o reads 0.
- R2: A write with wr_sel 0 (page, bits [7:0]), 1 (address) or 2 (count) loads the base and working copies of that register at the same clock edge.
- R3: A write with wr_sel 3 sets the mode: bit 0 selects word mode, bit 1 selects decrement, bit 2 enables autoinitialize and bit 3 is the mask bit (1 = masked).
- R4: A transfer strobe taken while unmasked adds 1 to the working address, or subtracts 1 in decrement mode. The address wraps within 16 bits without touching the page, and the working count drops by 1.
- R5: In byte mode addr_o[15:0] equals the working address and addr_o[23:16] equals the working page.
- R6: In word mode addr_o[0] is 0, addr_o[16:1] equals the working address and addr_o[23:17] equals working page bits [7:1].
- R7: A transfer taken while the working count is 0 is terminal. tc_o is high for the cycle after that edge, and without autoinitialize the count wraps to 0xFFFF.
- R8: A terminal transfer without autoinitialize sets the mask.
- R9: A terminal transfer with autoinitialize copies the base page, address and count into the working registers and leaves the mask clear.
- R10: svc_req_o is high in the cycle after an edge at which dreq_i was high and the channel is unmasked after that edge. While the channel is masked, dreq_i and xfer_i have no effect.
- R11: A processor write in the same cycle as a transfer wins for the register it targets, and a mode write decides the mask even at a terminal transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Processor write strobe |
| wr_sel | input | 2 | Register select: 0 page, 1 address, 2 count, 3 mode/mask |
| wr_data | input | 16 | Write data |
| dreq_i | input | 1 | Device request |
| xfer_i | input | 1 | Transfer cycle strobe |
| addr_o | output | 24 | Output address |
| svc_req_o | output | 1 | Qualified service request |
| mask_o | output | 1 | Channel mask state |
| tc_o | output | 1 | Terminal count pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit page, a 16-bit address and a 16-bit count. At these widths the 0xFFFF/0x0000 address wrap and the count wrap are both reachable by directed writes. Random count writes are kept below six, so terminal transfers with and without autoinitialize happen many times in each run. Random mode writes switch word and byte mapping, direction and masking while transfers are in flight. This makes write-versus-transfer collisions common.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        ST_MASKED  = 2'd0,
        ST_IDLE    = 2'd1,
        ST_REQUEST = 2'd2
    } chan_state_e;

    typedef enum logic [1:0] {
        SEL_PAGE  = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_MODE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic word;
        logic dec;
        logic autoinit;
    } chan_mode_t;

endpackage

// File: rtl/dmach_pair.sv
module dmach_pair #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic         step,
    input  logic [W-1:0] step_val,
    output logic [W-1:0] base_o,
    output logic [W-1:0] cur_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o <= '0;
            cur_o  <= '0;
        end else if (load) begin
            base_o <= load_val;
            cur_o  <= load_val;
        end else if (reload) begin
            cur_o  <= base_o;
        end else if (step) begin
            cur_o  <= step_val;
        end
    end

endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    input  logic              reload,
    output logic [PAGE_W-1:0] cur_page,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [CNT_W-1:0]  base_cnt,
    output chan_mode_t        mode
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    reg_sel_e           sel;
    logic               ld_page, ld_addr, ld_cnt, ld_mode;
    logic [PAGE_W-1:0]  base_page;
    logic [ADDR_W-1:0]  addr_next;
    logic [CNT_W-1:0]   cnt_next;

    always_comb begin
        sel     = reg_sel_e'(wr_sel);
        ld_page = wr_en && (sel == SEL_PAGE);
        ld_addr = wr_en && (sel == SEL_ADDR);
        ld_cnt  = wr_en && (sel == SEL_COUNT);
        ld_mode = wr_en && (sel == SEL_MODE);
        addr_next = mode.dec ? (cur_addr - ADDR_ONE) : (cur_addr + ADDR_ONE);
        cnt_next  = cur_cnt - CNT_ONE;
    end

    dmach_pair #(.W(PAGE_W)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_page),
        .load_val (wr_data[PAGE_W-1:0]),
        .reload   (reload),
        .step     (1'b0),
        .step_val (cur_page),
        .base_o   (base_page),
        .cur_o    (cur_page)
    );

    dmach_pair #(.W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_addr),
        .load_val (wr_data[ADDR_W-1:0]),
        .reload   (reload),
        .step     (step),
        .step_val (addr_next),
        .base_o   (base_addr),
        .cur_o    (cur_addr)
    );

    dmach_pair #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_cnt),
        .load_val (wr_data[CNT_W-1:0]),
        .reload   (reload),
        .step     (step),
        .step_val (cnt_next),
        .base_o   (base_cnt),
        .cur_o    (cur_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (ld_mode) begin
            mode.word     <= wr_data[0];
            mode.dec      <= wr_data[1];
            mode.autoinit <= wr_data[2];
        end
    end

endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic mask_bit,
    input  logic term,
    input  logic autoinit,
    input  logic dreq,
    output logic accept,
    output logic mask_o,
    output logic svc_req_o,
    output logic tc_o
);

    chan_state_e state, state_nxt;
    chan_state_e live_nxt;

    always_comb begin
        live_nxt  = dreq ? ST_REQUEST : ST_IDLE;
        state_nxt = state;
        unique case (state)
            ST_MASKED: begin
                if (mode_wr && !mask_bit) state_nxt = live_nxt;
            end
            ST_IDLE, ST_REQUEST: begin
                if (mode_wr)                state_nxt = mask_bit ? ST_MASKED : live_nxt;
                else if (term && !autoinit) state_nxt = ST_MASKED;
                else                        state_nxt = live_nxt;
            end
            default: state_nxt = ST_MASKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_MASKED;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tc_o <= 1'b0;
        else        tc_o <= term;
    end

    always_comb begin
        accept    = (state != ST_MASKED);
        mask_o    = (state == ST_MASKED);
        svc_req_o = (state == ST_REQUEST);
    end

endmodule

// File: rtl/dmach_addr_fmt.sv
module dmach_addr_fmt #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                     word,
    input  logic [PAGE_W-1:0]        page,
    input  logic [ADDR_W-1:0]        addr,
    output logic [PAGE_W+ADDR_W-1:0] addr_o
);

    always_comb begin
        if (word) addr_o = {page[PAGE_W-1:1], addr, 1'b0};
        else      addr_o = {page, addr};
    end

endmodule

// File: rtl/dmach_addr_gen.sv
module dmach_addr_gen
    import dmach_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     dreq_i,
    input  logic                     xfer_i,
    output logic [PAGE_W+ADDR_W-1:0] addr_o,
    output logic                     svc_req_o,
    output logic                     mask_o,
    output logic                     tc_o
);

    logic              accept, xfer_ok, term, mode_wr, reload;
    logic [PAGE_W-1:0] cur_page;
    logic [ADDR_W-1:0] cur_addr, base_addr;
    logic [CNT_W-1:0]  cur_cnt, base_cnt;
    chan_mode_t        mode;

    always_comb begin
        xfer_ok = xfer_i && accept;
        term    = xfer_ok && (cur_cnt == '0);
        reload  = term && mode.autoinit;
        mode_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
    end

    dmach_regs #(
        .PAGE_W (PAGE_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .step      (xfer_ok),
        .reload    (reload),
        .cur_page  (cur_page),
        .cur_addr  (cur_addr),
        .base_addr (base_addr),
        .cur_cnt   (cur_cnt),
        .base_cnt  (base_cnt),
        .mode      (mode)
    );

    dmach_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mask_bit  (wr_data[3]),
        .term      (term),
        .autoinit  (mode.autoinit),
        .dreq      (dreq_i),
        .accept    (accept),
        .mask_o    (mask_o),
        .svc_req_o (svc_req_o),
        .tc_o      (tc_o)
    );

    dmach_addr_fmt #(
        .PAGE_W (PAGE_W),
        .ADDR_W (ADDR_W)
    ) u_fmt (
        .word   (mode.word),
        .page   (cur_page),
        .addr   (cur_addr),
        .addr_o (addr_o)
    );

endmodule

// File: rtl/dmach_addr_gen_chk.sv
module dmach_addr_gen_chk #(
    parameter int OUT_W  = 24,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              xfer_ok,
    input logic              term,
    input logic              mode_word,
    input logic              mode_dec,
    input logic              mode_auto,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] base_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [CNT_W-1:0]  base_cnt,
    input logic [OUT_W-1:0]  addr_o,
    input logic              mask_o,
    input logic              svc_req_o,
    input logic              tc_o
);

    // R6
    word_a0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_word |-> (addr_o[0] == 1'b0));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && !wr_en && !(term && mode_auto)) |=>
        (cur_addr == ($past(mode_dec) ? ADDR_W'($past(cur_addr) - 1'b1)
                                      : ADDR_W'($past(cur_addr) + 1'b1))));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && !wr_en && !(term && mode_auto)) |=>
        (cur_cnt == CNT_W'($past(cur_cnt) - 1'b1)));

    // R7
    tc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> tc_o);

    // R8
    tc_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !mode_auto && !wr_en) |=> mask_o);

    // R9
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && mode_auto && !wr_en) |=>
        (!mask_o && cur_cnt == base_cnt && cur_addr == base_addr));

    // R10
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o && !wr_en) |=> ($stable(cur_addr) && $stable(cur_cnt) && !svc_req_o));

endmodule

bind dmach_addr_gen dmach_addr_gen_chk #(
    .OUT_W  (PAGE_W + ADDR_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .xfer_ok   (xfer_ok),
    .term      (term),
    .mode_word (mode.word),
    .mode_dec  (mode.dec),
    .mode_auto (mode.autoinit),
    .cur_addr  (cur_addr),
    .base_addr (base_addr),
    .cur_cnt   (cur_cnt),
    .base_cnt  (base_cnt),
    .addr_o    (addr_o),
    .mask_o    (mask_o),
    .svc_req_o (svc_req_o),
    .tc_o      (tc_o)
);

// File: tb/dmach_addr_gen_bench.sv
module dmach_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        dreq_i = 1'b0;
    logic        xfer_i = 1'b0;
    logic [23:0] addr_o;
    logic        svc_req_o, mask_o, tc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  m_bpage = 0, m_cpage = 0;
    logic [15:0] m_baddr = 0, m_caddr = 0, m_bcnt = 0, m_ccnt = 0;
    logic        m_word = 0, m_dec = 0, m_auto = 0, m_mask = 1, m_svc = 0, m_tc = 0;

    always #4 clk = ~clk;

    dmach_addr_gen u_dmach_addr_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .dreq_i    (dreq_i),
        .xfer_i    (xfer_i),
        .addr_o    (addr_o),
        .svc_req_o (svc_req_o),
        .mask_o    (mask_o),
        .tc_o      (tc_o)
    );

    function automatic logic [23:0] exp_addr(input logic word, input logic [7:0] pg,
                                             input logic [15:0] ad);
        if (word) return {pg[7:1], ad, 1'b0};
        return {pg, ad};
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk(m_word ? "R6 word address" : "R5 byte address", addr_o, exp_addr(m_word, m_cpage, m_caddr));
        chk("R8 mask", {23'd0, mask_o}, {23'd0, m_mask});
        chk("R10 service request", {23'd0, svc_req_o}, {23'd0, m_svc});
        chk("R7 terminal pulse", {23'd0, tc_o}, {23'd0, m_tc});
    endtask

    // drive one cycle (called at a falling edge), update the model, check at next falling edge
    task automatic cyc(input logic we, input logic [1:0] sel, input logic [15:0] d,
                       input logic rq, input logic xf);
        logic acc, term, old_auto;
        wr_en = we; wr_sel = sel; wr_data = d; dreq_i = rq; xfer_i = xf;
        acc = xf && !m_mask;
        term = acc && (m_ccnt == 16'd0);
        old_auto = m_auto;
        m_tc = term;
        if (acc) begin
            if (term && old_auto) begin
                m_cpage = m_bpage; m_caddr = m_baddr; m_ccnt = m_bcnt;
            end else begin
                m_caddr = m_dec ? m_caddr - 16'd1 : m_caddr + 16'd1;
                m_ccnt  = m_ccnt - 16'd1;
            end
        end
        if (we && sel == 2'd3) m_mask = d[3];
        else if (term && !old_auto) m_mask = 1'b1;
        if (we) begin
            case (sel)
                2'd0: begin m_bpage = d[7:0]; m_cpage = d[7:0]; end
                2'd1: begin m_baddr = d; m_caddr = d; end
                2'd2: begin m_bcnt = d; m_ccnt = d; end
                default: begin m_word = d[0]; m_dec = d[1]; m_auto = d[2]; end
            endcase
        end
        m_svc = !m_mask && rq;
        @(negedge clk);
        cmp_all();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0D3A_5C17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset address", addr_o, 24'h000000);
        chk("R1 reset mask", {23'd0, mask_o}, 24'd1);
        chk("R1 reset service", {23'd0, svc_req_o}, 24'd0);
        chk("R1 reset tc", {23'd0, tc_o}, 24'd0);

        // R10: masked channel ignores request and transfer
        cyc(1'b0, 2'd0, 16'd0, 1'b1, 1'b1);
        chk("R10 masked ignores xfer", addr_o, 24'h000000);

        // R2: page and address load
        cyc(1'b1, 2'd0, 16'h0012, 1'b0, 1'b0);
        chk("R2 page load", addr_o, 24'h120000);
        cyc(1'b1, 2'd1, 16'hFFFF, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 16'd1, 1'b0, 1'b0);
        // R3: mode write unmasks, byte increment
        cyc(1'b1, 2'd3, 16'h0000, 1'b1, 1'b0);
        chk("R3 unmasked", {23'd0, mask_o}, 24'd0);
        chk("R10 request forwarded", {23'd0, svc_req_o}, 24'd1);
        // R4: increment wraps in 16 bits, page untouched
        cyc(1'b0, 2'd0, 16'd0, 1'b1, 1'b1);
        chk("R4 address wrap", addr_o, 24'h120000);
        // R7/R8: second transfer is terminal, mask set
        cyc(1'b0, 2'd0, 16'd0, 1'b1, 1'b1);
        chk("R7 tc pulse", {23'd0, tc_o}, 24'd1);
        chk("R8 tc masks", {23'd0, mask_o}, 24'd1);
        cyc(1'b0, 2'd0, 16'd0, 1'b0, 1'b0);
        chk("R7 tc one cycle", {23'd0, tc_o}, 24'd0);

        // R6: word mode with odd page
        cyc(1'b1, 2'd0, 16'h0013, 1'b0, 1'b0);
        cyc(1'b1, 2'd1, 16'h4000, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 16'd0, 1'b0, 1'b0);
        cyc(1'b1, 2'd3, 16'h0007, 1'b0, 1'b0);
        chk("R6 word mapping", addr_o, 24'h128000);
        // R9: autoinit terminal reloads, mask stays clear
        cyc(1'b0, 2'd0, 16'd0, 1'b1, 1'b1);
        chk("R9 reload address", addr_o, 24'h128000);
        chk("R9 mask clear", {23'd0, mask_o}, 24'd0);
        // R4: decrement
        cyc(1'b1, 2'd2, 16'd5, 1'b0, 1'b0);
        cyc(1'b0, 2'd0, 16'd0, 1'b0, 1'b1);
        chk("R4 decrement", addr_o, 24'h127FFE);
        // R11: write wins over transfer
        cyc(1'b1, 2'd1, 16'h0100, 1'b0, 1'b1);
        chk("R11 write wins", addr_o, 24'h120200);

        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [1:0] sel;
            logic [15:0] d;
            we  = ($urandom % 6) == 0;
            sel = 2'($urandom % 4);
            d   = 16'($urandom);
            if (sel == 2'd2) d = 16'($urandom % 6);
            if (sel == 2'd3) d = {12'd0, (($urandom % 4) == 0), d[2:0]};
            cyc(we, sel, d, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule